// File: doc/BRIEF.md
# Lockable GPIO Bank with Pin Event Detection

The block is a bank of general-purpose I/O pins grouped into ports. Software reaches every pin through one indirect window: it first writes a pin number into a select register, and then the configuration, data and status registers all refer to that pin. Each pin has a direction bit, a choice of push-pull or open-drain drive, a pull-up request and a lock bit that can be set but never cleared by software. Once a pin is locked, its drive settings and its output value stay as they are until the next system reset.

The lowest-numbered ports can detect events. Each of their pins passes the pad input through a two-flop synchronizer and an optional debounce filter. It then raises its interrupt either on an edge, which sets a sticky status bit that software clears, or for as long as the input sits at an active level. The higher ports carry no event logic. Their event fields always read zero and their interrupt never asserts.

Register map (2-bit address): 0 = pin select (pin number in the low bits), 1 = configuration of the selected pin, 2 = data of the selected pin (bit 0 output value, bit 1 synchronized input, read only), 3 = event status of the selected pin (bit 0; writing 1 to bit 0 clears it). Reads are combinational from the address.

Top module: `gpio_bank`

## Requirements
- R1: Accesses at addresses 1, 2 and 3 act only on the pin whose number was last written to address 0, and address 0 reads back that number.
- R2: The configuration byte has the layout bit0 output enable, bit1 drive type, bit2 pull-up, bit3 lock, bit4 event type, bit5 event polarity, bit6 debounce enable, and bit7 is reserved and always reads 0.
- R3: With drive type 1 (push-pull) a pin drives pad_oe = output enable and pad_out = data. With drive type 0 (open-drain) pad_out = 0 and pad_oe = output enable AND NOT data. pad_od equals NOT drive type, and pad_pu equals the pull-up bit.
- R4: After reset, pins in event ports hold configuration 0x44, pins in other ports hold 0x04, and pin SPECIAL_PIN (default 14) holds 0x00. Address 0 reads 0.
- R5: Writing 1 to the lock bit sets it. Writing 0 never clears it, and only reset does.
- R6: While a pin is locked, writes to configuration bits 0 to 2 and to its output value are ignored, and its event bits stay writable.
- R7: For pins outside the event ports, configuration bits 4 to 6 read 0 and ignore writes.
- R8: Pins outside the event ports never assert evt_irq, and their status reads 0.
- R9: With event type 0 (edge), a change of the filtered input to the polarity level (polarity 1 = rising, 0 = falling) sets the pin's status bit. The bit stays set until a write of 1 to address 3, and evt_irq equals it. The opposite edge sets nothing.
- R10: With event type 1 (level), evt_irq is high exactly while the filtered input equals the polarity bit.
- R11: With debounce disabled, a pad change reaches the detector on the third clock edge after it. With debounce enabled, it must stay stable for DEBOUNCE_CYCLES consecutive cycles, so it arrives on edge 2 + DEBOUNCE_CYCLES, and shorter pulses are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for bus_addr |
| pad_in | input | NUM_PINS | Pad input levels |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| pad_pu | output | NUM_PINS | Pull-up requests |
| pad_od | output | NUM_PINS | Open-drain mode indicators |
| evt_irq | output | NUM_PINS | Per-pin event interrupts |

## Verification
The detector is driven with a clean rising step, a falling step under rising polarity, a held active level and a two-cycle glitch. These separate edge from level behaviour, show that polarity works and show that the filter drops short pulses. Timing is checked on both sides of the expected arrival edge, with and without debounce, so an extra or a missing register stage shows up. Drive checks cover all four combinations of drive type and data value. Lock checks write both values to each frozen field after locking, and confirm that the event fields still change.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef struct packed {
        logic rsvd;
        logic deb;
        logic pol;
        logic etype;
        logic lock;
        logic pu;
        logic ptype;
        logic oe;
    } cfg_t;

endpackage

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg
    import gpio_pkg::*;
#(
    parameter bit         EVENT_CAP = 1'b1,
    parameter logic [7:0] RESET_VAL = 8'h44
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic       dat_we,
    input  logic [7:0] wdata,
    output cfg_t       cfg,
    output logic       dout
);

    typedef struct packed {
        cfg_t cfg;
        logic dout;
    } pin_st_t;

    pin_st_t st_d, st_q;
    logic    unused_rsvd;

    assign unused_rsvd = wdata[7];

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            if (!st_q.cfg.lock) begin
                st_d.cfg.oe    = wdata[0];
                st_d.cfg.ptype = wdata[1];
                st_d.cfg.pu    = wdata[2];
            end
            st_d.cfg.lock = st_q.cfg.lock | wdata[3];
            if (EVENT_CAP) begin
                st_d.cfg.etype = wdata[4];
                st_d.cfg.pol   = wdata[5];
                st_d.cfg.deb   = wdata[6];
            end
        end
        if (dat_we && !st_q.cfg.lock) begin
            st_d.dout = wdata[0];
        end
        st_d.cfg.rsvd = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg  <= cfg_t'(RESET_VAL & 8'h7F);
            st_q.dout <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg  = st_q.cfg;
    assign dout = st_q.dout;

endmodule

// File: rtl/gpio_event.sv
module gpio_event #(
    parameter bit EVENT_CAP       = 1'b1,
    parameter int DEBOUNCE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_in,
    input  logic etype,
    input  logic pol,
    input  logic deb,
    input  logic clr,
    output logic sync_in,
    output logic status,
    output logic irq
);

    localparam int CW = $clog2(DEBOUNCE_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(DEBOUNCE_CYCLES - 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          filt;
        logic [CW-1:0] cnt;
        logic          status;
    } ev_st_t;

    ev_st_t st_d, st_q;
    logic   set_evt;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], pad_in};
        if (!deb) begin
            st_d.filt = st_q.sync[1];
            st_d.cnt  = '0;
        end else if (st_q.sync[1] != st_q.filt) begin
            if (st_q.cnt == CNT_LAST) begin
                st_d.filt = st_q.sync[1];
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
        set_evt     = EVENT_CAP && !etype && (st_d.filt != st_q.filt) && (st_d.filt == pol);
        st_d.status = (st_q.status & ~clr) | set_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_in = st_q.sync[1];
    assign status  = st_q.status;
    assign irq     = EVENT_CAP && (etype ? (st_q.filt == pol) : st_q.status);

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int NUM_PORTS       = 4,
    parameter int PINS_PER_PORT   = 4,
    parameter int EVENT_PORTS     = 2,
    parameter int SPECIAL_PIN     = 14,
    parameter int DEBOUNCE_CYCLES = 4,
    localparam int NUM_PINS       = NUM_PORTS * PINS_PER_PORT,
    localparam int PIN_W          = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          bus_addr,
    input  logic [7:0]          bus_wdata,
    input  logic                bus_wr,
    output logic [7:0]          bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_pu,
    output logic [NUM_PINS-1:0] pad_od,
    output logic [NUM_PINS-1:0] evt_irq
);

    localparam logic [1:0] A_SEL  = 2'd0;
    localparam logic [1:0] A_CFG  = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    typedef struct packed {
        logic [PIN_W-1:0] sel;
    } bank_st_t;

    bank_st_t st_d, st_q;

    cfg_t                pin_cfg [NUM_PINS];
    logic [NUM_PINS-1:0] pin_dout;
    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] pin_stat;
    logic [NUM_PINS-1:0] lock_vec;

    always_comb begin
        st_d = st_q;
        if (bus_wr && bus_addr == A_SEL) begin
            st_d.sel = bus_wdata[PIN_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        localparam bit EVC = ((i / PINS_PER_PORT) < EVENT_PORTS);
        localparam logic [7:0] RV = (i == SPECIAL_PIN) ? 8'h00 : (EVC ? 8'h44 : 8'h04);

        logic hit;
        assign hit = (st_q.sel == PIN_W'(i));

        gpio_pin_cfg #(
            .EVENT_CAP (EVC),
            .RESET_VAL (RV)
        ) u_cfg (
            .clk    (clk),
            .rst_n  (rst_n),
            .cfg_we (bus_wr && hit && bus_addr == A_CFG),
            .dat_we (bus_wr && hit && bus_addr == A_DATA),
            .wdata  (bus_wdata),
            .cfg    (pin_cfg[i]),
            .dout   (pin_dout[i])
        );

        gpio_event #(
            .EVENT_CAP       (EVC),
            .DEBOUNCE_CYCLES (DEBOUNCE_CYCLES)
        ) u_evt (
            .clk     (clk),
            .rst_n   (rst_n),
            .pad_in  (pad_in[i]),
            .etype   (pin_cfg[i].etype),
            .pol     (pin_cfg[i].pol),
            .deb     (pin_cfg[i].deb),
            .clr     (bus_wr && hit && bus_addr == A_STAT && bus_wdata[0]),
            .sync_in (pin_sync[i]),
            .status  (pin_stat[i]),
            .irq     (evt_irq[i])
        );

        assign lock_vec[i] = pin_cfg[i].lock;
        assign pad_od[i]   = ~pin_cfg[i].ptype;
        assign pad_pu[i]   = pin_cfg[i].pu;
        assign pad_out[i]  = pin_cfg[i].ptype & pin_dout[i];
        assign pad_oe[i]   = pin_cfg[i].oe & (pin_cfg[i].ptype | ~pin_dout[i]);
    end

    always_comb begin
        case (bus_addr)
            A_SEL:   bus_rdata = 8'(st_q.sel);
            A_CFG:   bus_rdata = pin_cfg[st_q.sel];
            A_DATA:  bus_rdata = {6'b0, pin_sync[st_q.sel], pin_dout[st_q.sel]};
            default: bus_rdata = {7'b0, pin_stat[st_q.sel]};
        endcase
    end

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int NUM_PINS      = 16,
    parameter int PINS_PER_PORT = 4,
    parameter int EVENT_PORTS   = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] lock_vec,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pad_pu,
    input logic [NUM_PINS-1:0] pad_od,
    input logic [NUM_PINS-1:0] evt_irq,
    input logic [7:0]          bus_rdata
);

    localparam int EV_PINS = EVENT_PORTS * PINS_PER_PORT;

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lock_vec & $past(lock_vec)) == $past(lock_vec))); // R5

    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((((pad_out ^ $past(pad_out)) | (pad_oe ^ $past(pad_oe)) |
                    (pad_pu ^ $past(pad_pu)) | (pad_od ^ $past(pad_od))) & $past(lock_vec)) == '0)); // R6

    AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_od & pad_oe & pad_out) == '0); // R3

    AST_NOEV_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_irq >> EV_PINS) == '0); // R8

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[7] == 1'b0); // R2

endmodule

bind gpio_bank gpio_bank_chk #(
    .NUM_PINS      (NUM_PINS),
    .PINS_PER_PORT (PINS_PER_PORT),
    .EVENT_PORTS   (EVENT_PORTS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_vec  (lock_vec),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu),
    .pad_od    (pad_od),
    .evt_irq   (evt_irq),
    .bus_rdata (bus_rdata)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NPINS      = 16;
    localparam int DEB        = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [1:0]       bus_addr;
    logic [7:0]       bus_wdata;
    logic             bus_wr;
    logic [7:0]       bus_rdata;
    logic [NPINS-1:0] pad_in;
    logic [NPINS-1:0] pad_out, pad_oe, pad_pu, pad_od, evt_irq;

    int nvec  = 0;
    int nfail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gpio_bank #(.DEBOUNCE_CYCLES(DEB)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_od(pad_od), .evt_irq(evt_irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic cycles(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(2'd0, d); check("R4 select reset", d, 8'h00);
        rd(2'd1, d); check("R4 pin0 reset", d, 8'h44);
        wr(2'd0, 8'd5);  rd(2'd0, d); check("R1 select readback", d, 8'd5);
        rd(2'd1, d); check("R4 pin5 reset", d, 8'h44);
        wr(2'd0, 8'd8);  rd(2'd1, d); check("R4 pin8 reset", d, 8'h04);
        wr(2'd0, 8'd14); rd(2'd1, d); check("R4 pin14 reset", d, 8'h00);
        wr(2'd0, 8'd7);  wr(2'd1, 8'h45);
        wr(2'd0, 8'd6);  rd(2'd1, d); check("R1 neighbour untouched", d, 8'h44);
        wr(2'd0, 8'd7);  rd(2'd1, d); check("R1 selected pin written", d, 8'h45);
    endtask

    task automatic t_layout;
        logic [7:0] d;
        wr(2'd0, 8'd1); wr(2'd1, 8'hF7); rd(2'd1, d); check("R2 bit7 reads 0", d, 8'h77);
        check("R3 pu from bit2", {7'b0, pad_pu[1]}, 8'h01);
        wr(2'd0, 8'd9); wr(2'd1, 8'h77); rd(2'd1, d); check("R7 event bits zero", d, 8'h07);
    endtask

    task automatic t_drive;
        wr(2'd0, 8'd2);
        wr(2'd1, 8'h03); wr(2'd2, 8'h01);
        check("R3 pp high", {5'b0, pad_od[2], pad_oe[2], pad_out[2]}, 8'h03);
        wr(2'd2, 8'h00);
        check("R3 pp low", {5'b0, pad_od[2], pad_oe[2], pad_out[2]}, 8'h02);
        wr(2'd1, 8'h01);
        check("R3 od low", {5'b0, pad_od[2], pad_oe[2], pad_out[2]}, 8'h06);
        wr(2'd2, 8'h01);
        check("R3 od release", {5'b0, pad_od[2], pad_oe[2], pad_out[2]}, 8'h04);
        check("R3 pu off", {7'b0, pad_pu[2]}, 8'h00);
    endtask

    task automatic t_lock;
        logic [7:0] d;
        wr(2'd0, 8'd3);
        wr(2'd1, 8'h03); wr(2'd2, 8'h01);
        wr(2'd1, 8'h0B); rd(2'd1, d); check("R5 lock set", d, 8'h0B);
        wr(2'd1, 8'h00); rd(2'd1, d); check("R5 lock not cleared", d, 8'h0B);
        wr(2'd2, 8'h00); rd(2'd2, d);
        check("R6 data write ignored", {7'b0, d[0]}, 8'h01);
        check("R6 pads frozen", {6'b0, pad_oe[3], pad_out[3]}, 8'h03);
        wr(2'd1, 8'h70); rd(2'd1, d); check("R6 event bits writable", d, 8'h7B);
    endtask

    task automatic t_noev;
        logic [7:0] d;
        wr(2'd0, 8'd10);
        pad_in[10] = 1'b1; cycles(4);
        rd(2'd2, d); check("R1 input readback", {7'b0, d[1]}, 8'h01);
        pad_in[10] = 1'b0; cycles(4);
        check("R8 no irq", {7'b0, evt_irq[10]}, 8'h00);
        rd(2'd3, d); check("R8 status zero", d, 8'h00);
    endtask

    task automatic t_edge;
        logic [7:0] d;
        wr(2'd0, 8'd4); wr(2'd1, 8'h24);
        pad_in[4] = 1'b1;
        cycles(2); check("R11 no-deb not yet", {7'b0, evt_irq[4]}, 8'h00);
        cycles(1); check("R9 rising sets irq", {7'b0, evt_irq[4]}, 8'h01);
        pad_in[4] = 1'b0; cycles(5);
        check("R9 sticky", {7'b0, evt_irq[4]}, 8'h01);
        rd(2'd3, d); check("R9 status read", d, 8'h01);
        pad_in[4] = 1'b1; cycles(5);
        wr(2'd3, 8'h01);
        check("R9 cleared", {7'b0, evt_irq[4]}, 8'h00);
        pad_in[4] = 1'b0; cycles(5);
        check("R9 falling ignored", {7'b0, evt_irq[4]}, 8'h00);
        rd(2'd3, d); check("R9 status stays 0", d, 8'h00);
    endtask

    task automatic t_level;
        wr(2'd0, 8'd5); wr(2'd1, 8'h14);
        check("R10 low level active", {7'b0, evt_irq[5]}, 8'h01);
        pad_in[5] = 1'b1;
        cycles(2); check("R10 still active", {7'b0, evt_irq[5]}, 8'h01);
        cycles(1); check("R10 level gone", {7'b0, evt_irq[5]}, 8'h00);
        wr(2'd1, 8'h34);
        check("R10 high level active", {7'b0, evt_irq[5]}, 8'h01);
    endtask

    task automatic t_debounce;
        wr(2'd0, 8'd6); wr(2'd1, 8'h64);
        pad_in[6] = 1'b1; cycles(2);
        pad_in[6] = 1'b0; cycles(10);
        check("R11 glitch dropped", {7'b0, evt_irq[6]}, 8'h00);
        pad_in[6] = 1'b1;
        cycles(2 + DEB - 1); check("R11 deb not yet", {7'b0, evt_irq[6]}, 8'h00);
        cycles(1); check("R11 deb passes", {7'b0, evt_irq[6]}, 8'h01);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; pad_in = '0;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        t_reset;
        t_layout;
        t_drive;
        t_lock;
        t_noev;
        t_edge;
        t_level;
        t_debounce;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule